// File: doc/BRIEF.md
# Serial ADC Conversion Sequencer

This block is the host side of a link to a 12-bit serial analog-to-digital converter with eight inputs. It drives the converter's chip-select, serial clock and data-in lines, and it reads the converter's data-out line. After reset it keeps the link idle for a fixed settling interval. It then holds chip-select low for good, clocks sixteen zero bits to bring the converter to a known state, and from then on issues conversions back to back with no gap between them.

Each conversion frame opens with an eight-bit command. The command carries a leading one and the channel to convert. The 12-bit answer to one frame arrives while the next frame's command is going out. The frame length is selectable: a 16-clock frame that keeps commands on byte boundaries, or a 15-clock frame that packs conversions as tightly as the converter allows. The serial clock comes from dividing the system clock by a programmable half-period. That half-period is forced into the range the converter accepts, and the range is tighter when the slow compensation option is selected. Each finished result is presented with its channel number and a one-cycle strobe.

Top module: `adc_conv_seq`

## Requirements
- R1: For POR_US microseconds after reset (SYS_HZ/1e6*POR_US system cycles), `adc_cs_n` is high, and `adc_sclk` and `adc_din` are low.
- R2: When the settling interval ends, `adc_cs_n` goes low and stays low until the next reset. The next 16 serial clock periods carry a zero on `adc_din`, and only then does the first command start.
- R3: Each frame begins with a command sent MSB first. Bit 7 is 1, bits 6:4 are the channel number and bits 3:0 are 1111. `adc_din` is 0 in every slot of the frame after the command.
- R4: With `cfg_mode16` = 1, a new command starts every 16 serial clock periods.
- R5: With `cfg_mode16` = 0, a new command starts every 15 serial clock periods.
- R6: Slots are counted from 0, where slot 0 carries the leading one. `adc_dout` is sampled, MSB first, on the rising serial-clock edges of slots 9 to 20 of the frame. `res_valid` pulses for exactly one system cycle on the clock after the twelfth sample, and `res_data` then holds the twelve bits.
- R7: Each serial clock half-period lasts `cfg_half_div` system cycles. With `cfg_slow` = 0, a smaller value is raised to ceil(SYS_HZ/(2*SCLK_MAX_HZ)), which is 25 cycles at 100 MHz.
- R8: With `cfg_slow` = 1, a half-period below ceil(SYS_HZ/(2*SCLK_SLOW_HZ)) is raised to that value, which is 125 cycles at 100 MHz.
- R9: A half-period above floor(SYS_HZ/(2*SCLK_MIN_HZ)) is lowered to that value, which is 500 cycles at 100 MHz.
- R10: `adc_sclk` idles low, begins with a low half-period in the cycle chip-select falls, and `adc_din` changes only on its falling edges.
- R11: `chan_next` is sampled at the falling edge that starts each frame, and `res_chan` reports the channel sent in the command of the frame the result belongs to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_half_div | input | DIV_W | Requested serial clock half-period in system cycles |
| cfg_slow | input | 1 | Selects the slow compensation option and its lower rate ceiling |
| cfg_mode16 | input | 1 | 1 selects 16-clock frames, 0 selects 15-clock frames |
| chan_next | input | 3 | Channel for the next command |
| adc_cs_n | output | 1 | Converter chip-select, active low |
| adc_sclk | output | 1 | Serial clock to the converter |
| adc_din | output | 1 | Serial command data to the converter |
| adc_dout | input | 1 | Serial result data from the converter |
| res_valid | output | 1 | One-cycle strobe marking a new result |
| res_chan | output | 3 | Channel the result belongs to |
| res_data | output | 12 | Conversion result |

## Verification
The assertions check, on every cycle, the properties that hold at all times. The link stays quiet while chip-select is high, and chip-select never rises again once it has fallen. Data-in moves only on falling serial-clock edges, every serial half-period lies between the rate limits in force, and the result strobe never lasts longer than one cycle. Some behaviour can only be shown by the bench scenarios, which compare every pin against a behavioural model on every clock. This covers the exact settling length and the sixteen-zero flush. It also covers the command bits and channel order, the 15-clock and 16-clock frame spacing, the clamped divider value in each of the three limit cases, and the pairing of each captured word with the channel of the frame that requested it.

// File: rtl/adc_seq_pkg.sv
// Package: shared constants, types and helpers of the conversion sequencer.
// Assumes: an 8-bit command with a leading one, a 3-bit channel, a 12-bit result.
package adc_seq_pkg;

    localparam int CHAN_W      = 3;
    localparam int RES_W       = 12;
    localparam int CMD_W       = 8;
    localparam int SLOT_W      = 5;
    localparam int FLUSH_SLOTS = 16;
    localparam int RX_SLOT0    = 9;

    typedef enum logic [1:0] {
        PH_SETTLE = 2'd0,
        PH_FLUSH  = 2'd1,
        PH_RUN    = 2'd2
    } seq_phase_t;

    // Builds a command: leading one, channel, then single-ended/unipolar/external-clock bits
    function automatic logic [CMD_W-1:0] make_cmd(input logic [CHAN_W-1:0] ch);
        return {1'b1, ch, 4'b1111};
    endfunction

endpackage

// File: rtl/adc_sclk_gen.sv
// Module: serial clock divider with rate clamp.
// Produces adc_sclk from the system clock while run is high, starting with a
// low half. rise_tk/fall_tk are high in the cycle whose closing edge makes
// sclk rise/fall. Assumes cfg_half_div and cfg_slow change only while run is low.
module adc_sclk_gen #(
    parameter int SYS_HZ       = 100_000_000,
    parameter int SCLK_MAX_HZ  = 2_000_000,
    parameter int SCLK_SLOW_HZ = 400_000,
    parameter int SCLK_MIN_HZ  = 100_000,
    parameter int DIV_W        = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] cfg_half_div,
    input  logic             cfg_slow,
    output logic             sclk,
    output logic             rise_tk,
    output logic             fall_tk
);
    localparam int HALF_MIN_FAST = (SYS_HZ + 2*SCLK_MAX_HZ - 1) / (2*SCLK_MAX_HZ);
    localparam int HALF_MIN_SLOW = (SYS_HZ + 2*SCLK_SLOW_HZ - 1) / (2*SCLK_SLOW_HZ);
    localparam int HALF_MAX      = SYS_HZ / (2*SCLK_MIN_HZ);
    localparam logic [DIV_W-1:0] LIM_FAST = DIV_W'(HALF_MIN_FAST);
    localparam logic [DIV_W-1:0] LIM_SLOW = DIV_W'(HALF_MIN_SLOW);
    localparam logic [DIV_W-1:0] LIM_MAX  = DIV_W'(HALF_MAX);

    logic [DIV_W-1:0] half_q;
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] lo_lim;
    logic [DIV_W-1:0] half_d;
    logic             sclk_q;
    logic             wrap;

    // Clamps the requested half-period into the legal range for the option in use
    always_comb begin
        lo_lim = cfg_slow ? LIM_SLOW : LIM_FAST;
        if (cfg_half_div < lo_lim)
            half_d = lo_lim;
        else if (cfg_half_div > LIM_MAX)
            half_d = LIM_MAX;
        else
            half_d = cfg_half_div;
    end

    assign wrap    = run && (cnt_q == half_q - 1'b1);
    assign rise_tk = wrap && !sclk_q;
    assign fall_tk = wrap && sclk_q;
    assign sclk    = sclk_q;

    // Counts system cycles within a half-period and toggles the serial clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            sclk_q <= 1'b0;
            half_q <= LIM_FAST;
        end else if (!run) begin
            cnt_q  <= '0;
            sclk_q <= 1'b0;
            half_q <= half_d;
        end else if (wrap) begin
            cnt_q  <= '0;
            sclk_q <= ~sclk_q;
            half_q <= half_d;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/adc_frame_ctrl.sv
// Module: phase and frame sequencer.
// Waits out the settling interval, flushes sixteen zero slots, then issues
// commands back to back. All slot changes happen on fall_tk. Assumes
// POR_CYC >= 1 and a frame of 15 or 16 slots.
module adc_frame_ctrl
    import adc_seq_pkg::*;
#(
    parameter int POR_CYC = 10_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall_tk,
    input  logic              cfg_mode16,
    input  logic [CHAN_W-1:0] chan_next,
    output logic              run,
    output logic              in_frame,
    output logic [SLOT_W-1:0] slot,
    output logic [CHAN_W-1:0] frame_chan,
    output logic              cs_n,
    output logic              din
);
    localparam int POR_W = $clog2(POR_CYC + 1);
    localparam logic [POR_W-1:0]  POR_LAST   = POR_W'(POR_CYC - 1);
    localparam logic [SLOT_W-1:0] FLUSH_LAST = SLOT_W'(FLUSH_SLOTS - 1);

    seq_phase_t        phase_q;
    logic [POR_W-1:0]  por_q;
    logic [SLOT_W-1:0] slot_q;
    logic [CMD_W-1:0]  cmd_q;
    logic [CHAN_W-1:0] chan_q;
    logic              mode16_q;
    logic [SLOT_W-1:0] frame_last;

    assign frame_last = mode16_q ? SLOT_W'(15) : SLOT_W'(14);
    assign cs_n       = (phase_q == PH_SETTLE);
    assign run        = !cs_n;
    assign in_frame   = (phase_q == PH_RUN);
    assign slot       = slot_q;
    assign frame_chan = chan_q;
    assign din        = cmd_q[CMD_W-1];

    // Advances settle counter, flush slots and frame slots; loads each command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_SETTLE;
            por_q    <= '0;
            slot_q   <= '0;
            cmd_q    <= '0;
            chan_q   <= '0;
            mode16_q <= 1'b1;
        end else begin
            case (phase_q)
                PH_SETTLE: begin
                    if (por_q == POR_LAST) begin
                        phase_q <= PH_FLUSH;
                        slot_q  <= '0;
                    end else begin
                        por_q <= por_q + 1'b1;
                    end
                end
                PH_FLUSH: begin
                    if (fall_tk) begin
                        if (slot_q == FLUSH_LAST) begin
                            phase_q  <= PH_RUN;
                            slot_q   <= '0;
                            cmd_q    <= make_cmd(chan_next);
                            chan_q   <= chan_next;
                            mode16_q <= cfg_mode16;
                        end else begin
                            slot_q <= slot_q + 1'b1;
                        end
                    end
                end
                PH_RUN: begin
                    if (fall_tk) begin
                        if (slot_q == frame_last) begin
                            slot_q   <= '0;
                            cmd_q    <= make_cmd(chan_next);
                            chan_q   <= chan_next;
                            mode16_q <= cfg_mode16;
                        end else begin
                            slot_q <= slot_q + 1'b1;
                            cmd_q  <= {cmd_q[CMD_W-2:0], 1'b0};
                        end
                    end
                end
                default: phase_q <= PH_SETTLE;
            endcase
        end
    end

endmodule

// File: rtl/adc_rx_capture.sv
// Module: result deserializer.
// Starts a capture on the rising edge of frame slot RX_SLOT0 and takes RES_W
// bits MSB first on consecutive rising edges. The capture runs on into the
// next frame. Assumes frames are long enough that captures never overlap.
module adc_rx_capture
    import adc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise_tk,
    input  logic              in_frame,
    input  logic [SLOT_W-1:0] slot,
    input  logic [CHAN_W-1:0] frame_chan,
    input  logic              dout,
    output logic              res_valid,
    output logic [CHAN_W-1:0] res_chan,
    output logic [RES_W-1:0]  res_data
);
    localparam int CNT_W = $clog2(RES_W + 1);
    localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(RES_W - 1);
    localparam logic [SLOT_W-1:0] RX_START = SLOT_W'(RX_SLOT0);

    logic              busy_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [RES_W-1:0]  acc_q;
    logic [CHAN_W-1:0] chan_q;

    // Shifts in result bits and publishes the word with its channel
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q    <= 1'b0;
            cnt_q     <= '0;
            acc_q     <= '0;
            chan_q    <= '0;
            res_valid <= 1'b0;
            res_chan  <= '0;
            res_data  <= '0;
        end else begin
            res_valid <= 1'b0;
            if (rise_tk) begin
                if (!busy_q && in_frame && slot == RX_START) begin
                    busy_q <= 1'b1;
                    cnt_q  <= CNT_W'(1);
                    acc_q  <= RES_W'(dout);
                    chan_q <= frame_chan;
                end else if (busy_q) begin
                    acc_q <= {acc_q[RES_W-2:0], dout};
                    if (cnt_q == CNT_LAST) begin
                        busy_q    <= 1'b0;
                        res_valid <= 1'b1;
                        res_data  <= {acc_q[RES_W-2:0], dout};
                        res_chan  <= chan_q;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/adc_conv_seq.sv
// Module: top of the serial ADC conversion sequencer.
// Ties the clock divider, the frame sequencer and the result deserializer
// together. Assumes the configuration inputs are held steady outside reset.
module adc_conv_seq
    import adc_seq_pkg::*;
#(
    parameter int SYS_HZ       = 100_000_000,
    parameter int POR_US       = 100,
    parameter int SCLK_MAX_HZ  = 2_000_000,
    parameter int SCLK_SLOW_HZ = 400_000,
    parameter int SCLK_MIN_HZ  = 100_000,
    parameter int DIV_W        = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] cfg_half_div,
    input  logic             cfg_slow,
    input  logic             cfg_mode16,
    input  logic [2:0]       chan_next,
    output logic             adc_cs_n,
    output logic             adc_sclk,
    output logic             adc_din,
    input  logic             adc_dout,
    output logic             res_valid,
    output logic [2:0]       res_chan,
    output logic [11:0]      res_data
);
    localparam int POR_CYC = (SYS_HZ / 1_000_000) * POR_US;

    logic              run;
    logic              in_frame;
    logic              rise_tk;
    logic              fall_tk;
    logic [SLOT_W-1:0] slot;
    logic [CHAN_W-1:0] frame_chan;

    adc_sclk_gen #(
        .SYS_HZ      (SYS_HZ),
        .SCLK_MAX_HZ (SCLK_MAX_HZ),
        .SCLK_SLOW_HZ(SCLK_SLOW_HZ),
        .SCLK_MIN_HZ (SCLK_MIN_HZ),
        .DIV_W       (DIV_W)
    ) u_sclk (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .cfg_half_div(cfg_half_div),
        .cfg_slow    (cfg_slow),
        .sclk        (adc_sclk),
        .rise_tk     (rise_tk),
        .fall_tk     (fall_tk)
    );

    adc_frame_ctrl #(
        .POR_CYC(POR_CYC)
    ) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .fall_tk   (fall_tk),
        .cfg_mode16(cfg_mode16),
        .chan_next (chan_next),
        .run       (run),
        .in_frame  (in_frame),
        .slot      (slot),
        .frame_chan(frame_chan),
        .cs_n      (adc_cs_n),
        .din       (adc_din)
    );

    adc_rx_capture u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_tk   (rise_tk),
        .in_frame  (in_frame),
        .slot      (slot),
        .frame_chan(frame_chan),
        .dout      (adc_dout),
        .res_valid (res_valid),
        .res_chan  (res_chan),
        .res_data  (res_data)
    );

endmodule

// File: rtl/adc_conv_seq_chk.sv
// Module: property checker for the conversion sequencer, bound to the top.
// Watches only the pins of the top. Assumes cfg_slow is steady outside reset.
module adc_conv_seq_chk #(
    parameter int SYS_HZ       = 100_000_000,
    parameter int SCLK_MAX_HZ  = 2_000_000,
    parameter int SCLK_SLOW_HZ = 400_000,
    parameter int SCLK_MIN_HZ  = 100_000
) (
    input logic clk,
    input logic rst_n,
    input logic cfg_slow,
    input logic adc_cs_n,
    input logic adc_sclk,
    input logic adc_din,
    input logic res_valid
);
    localparam int LO_FAST = (SYS_HZ + 2*SCLK_MAX_HZ - 1) / (2*SCLK_MAX_HZ);
    localparam int LO_SLOW = (SYS_HZ + 2*SCLK_SLOW_HZ - 1) / (2*SCLK_SLOW_HZ);
    localparam int HI      = SYS_HZ / (2*SCLK_MIN_HZ);

    logic sclk_prev;
    int   held;
    int   lo_now;

    assign lo_now = cfg_slow ? LO_SLOW : LO_FAST;

    // Measures how many cycles the serial clock has kept its present level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
            held      <= 0;
        end else begin
            sclk_prev <= adc_sclk;
            if (adc_cs_n)
                held <= 0;
            else if (adc_sclk != sclk_prev)
                held <= 1;
            else
                held <= held + 1;
        end
    end

    AST_SETTLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        adc_cs_n |-> (!adc_sclk && !adc_din)); // R1

    AST_CS_STAYS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_cs_n |=> !adc_cs_n); // R2

    AST_DIN_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!adc_cs_n && !$fell(adc_sclk)) |-> $stable(adc_din)); // R10

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid); // R6

    AST_HALF_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!adc_cs_n && adc_sclk != sclk_prev) |-> (held >= lo_now && held <= HI)); // R7

endmodule

bind adc_conv_seq adc_conv_seq_chk #(
    .SYS_HZ      (SYS_HZ),
    .SCLK_MAX_HZ (SCLK_MAX_HZ),
    .SCLK_SLOW_HZ(SCLK_SLOW_HZ),
    .SCLK_MIN_HZ (SCLK_MIN_HZ)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_slow (cfg_slow),
    .adc_cs_n (adc_cs_n),
    .adc_sclk (adc_sclk),
    .adc_din  (adc_din),
    .res_valid(res_valid)
);

// File: tb/adc_conv_seq_test.sv
// Bench: behavioural timing model of the link and a converter model, compared
// with every pin of the sequencer on every system clock.
module adc_conv_seq_test;

    localparam int POR = 10_000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_half_div = 16'd10;
    logic        cfg_slow = 1'b0;
    logic        cfg_mode16 = 1'b1;
    logic [2:0]  chan_next = 3'd0;
    logic        adc_dout = 1'b0;
    logic        adc_cs_n, adc_sclk, adc_din, res_valid;
    logic [2:0]  res_chan;
    logic [11:0] res_data;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    active = 1'b0;
    bit    done = 1'b0;
    int    t = 0;
    int    H = 25;
    int    L = 16;
    int    seed = 0;
    int    loads = 0;
    int    seen = 0;
    int    chan_of[64];

    always #5 clk = ~clk;

    adc_conv_seq uut (
        .clk(clk), .rst_n(rst_n), .cfg_half_div(cfg_half_div), .cfg_slow(cfg_slow),
        .cfg_mode16(cfg_mode16), .chan_next(chan_next), .adc_cs_n(adc_cs_n),
        .adc_sclk(adc_sclk), .adc_din(adc_din), .adc_dout(adc_dout),
        .res_valid(res_valid), .res_chan(res_chan), .res_data(res_data)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at t=%0d: actual=%0d expected=%0d", tag, t, act, exp);
        end
    endtask

    function automatic int res_of(input int n);
        return ((chan_of[n] << 9) ^ (n * 1443 + seed)) & 12'hFFF;
    endfunction

    // Model time: counts edges since reset release and records each command's channel
    always @(posedge clk) begin
        if (active && rst_n) begin
            int u;
            t = t + 1;
            u = t - POR;
            if (u >= 0 && (u % (2*H)) == 0) begin
                int s;
                s = u / (2*H);
                if (s >= 16 && ((s - 16) % L) == 0) begin
                    chan_of[(s - 16) / L] = int'(chan_next);
                    loads = (s - 16) / L + 1;
                end
            end
        end
    end

    task automatic compare_cycle(input string clk_tag, input string frm_tag);
        int u;
        bit e_cs, e_sclk, e_din, e_val;
        int e_n;
        u = t - POR;
        e_cs = (u < 0);
        e_sclk = 1'b0;
        e_din = 1'b0;
        e_val = 1'b0;
        e_n = 0;
        if (u >= 0) begin
            int s;
            e_sclk = ((u / H) % 2) == 1;
            s = u / (2*H);
            if (s >= 16) begin
                int f, k;
                logic [7:0] cmd;
                f = s - 16;
                k = f % L;
                cmd = {1'b1, 3'(chan_of[f / L]), 4'b1111};
                if (k < 8) e_din = cmd[7-k];
            end
            if (u - H >= 0 && ((u - H) % (2*H)) == 0) begin
                int s2;
                s2 = (u - H) / (2*H) - 36;
                if (s2 >= 0 && (s2 % L) == 0) begin
                    e_val = 1'b1;
                    e_n = s2 / L;
                end
            end
        end
        chk(adc_cs_n == e_cs, "R1 R2 chip-select", int'(adc_cs_n), int'(e_cs));
        chk(adc_sclk == e_sclk, clk_tag, int'(adc_sclk), int'(e_sclk));
        chk(adc_din == e_din, (u >= 0 && u / (2*H) < 16) ? "R2 flush" : frm_tag,
            int'(adc_din), int'(e_din));
        chk(res_valid == e_val, "R6 strobe", int'(res_valid), int'(e_val));
        if (e_val) begin
            seen++;
            chk(int'(res_data) == res_of(e_n), "R6 data", int'(res_data), res_of(e_n));
            chk(int'(res_chan) == chan_of[e_n], "R11 channel", int'(res_chan), chan_of[e_n]);
        end
    endtask

    task automatic drive_cycle();
        int u;
        u = t - POR;
        adc_dout = 1'b0;
        if (u >= 0 && u / (2*H) >= 16) begin
            int f;
            f = u / (2*H) - 16;
            for (int m = f / L - 1; m <= f / L; m++) begin
                int k;
                k = f - m * L;
                if (m >= 0 && k >= 9 && k <= 20)
                    adc_dout = ((res_of(m) >> (20 - k)) & 1) == 1;
            end
        end
        chan_next = 3'((seed + loads * 3) % 8);
    endtask

    task automatic run_scn(input int cfg, input bit slow, input bit m16, input int hexp,
                           input int nf, input int sd, input string clk_tag,
                           input string frm_tag);
        int ncyc;
        active = 1'b0;
        rst_n = 1'b0;
        cfg_half_div = 16'(cfg);
        cfg_slow = slow;
        cfg_mode16 = m16;
        H = hexp;
        L = m16 ? 16 : 15;
        seed = sd;
        loads = 0;
        seen = 0;
        t = 0;
        chan_next = 3'(sd % 8);
        adc_dout = 1'b0;
        repeat (3) @(negedge clk);
        chk(adc_cs_n == 1'b1, "R1 reset cs", int'(adc_cs_n), 1);
        chk(adc_sclk == 1'b0, "R1 reset sclk", int'(adc_sclk), 0);
        chk(adc_din == 1'b0, "R1 reset din", int'(adc_din), 0);
        chk(res_valid == 1'b0, "R6 reset strobe", int'(res_valid), 0);
        rst_n = 1'b1;
        active = 1'b1;
        ncyc = POR + 2 * H * (16 + L * nf + 21);
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            compare_cycle(clk_tag, frm_tag);
            drive_cycle();
        end
        chk(seen == nf + 1, "R6 result count", seen, nf + 1);
        active = 1'b0;
    endtask

    // Scenario sequence: one run per frame mode and per clamp limit
    initial begin
        run_scn(10, 1'b0, 1'b1, 25, 6, 5, "R7 R10 sclk", "R3 R4 din");
        run_scn(30, 1'b0, 1'b0, 30, 6, 2, "R7 R10 sclk", "R3 R5 din");
        run_scn(40, 1'b1, 1'b1, 125, 2, 7, "R8 R10 sclk", "R3 R4 din");
        run_scn(3000, 1'b0, 1'b0, 500, 1, 3, "R9 R10 sclk", "R3 R5 din");
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        end
        $finish;
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (190_000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        end
        $finish;
    end

endmodule